// File: doc/BRIEF.md
# Scanline Band Dispatcher for Multi-Chip Rendering

This block sits in front of a group of one, two or four rendering chips. It decides, for every pixel coordinate offered to it, which chip or chips must render that pixel and which sub-sample slots each selected chip produces. The screen is cut into horizontal bands whose height in scanlines is a power of two. In the ordinary case the bands are dealt out to the chips in rotation. When four sub-samples per pixel are requested, the rotation is narrowed to pairs of chips. Both chips of the owning pair take the pixel, and each produces half of its samples, because one chip can produce only two sub-samples per clock.

The configuration consists of the chip count, the anti-aliasing sample count and the band height. It is presented on input pins and captured only on a frame-start pulse, so a change in the middle of a frame has no effect. The block also reports how much frame-buffer storage each chip needs. This figure is given in quarters of one normal single-sample full-frame buffer. It flags configurations that cannot be built and falls back to a single chip at one sample per pixel. The pixel handshake is combinational: a pixel moves to every selected chip in the same cycle, or to none of them.

Top module: `band_dispatch`

## Requirements
- R1: After reset, the active setup is one chip, one sample per pixel and a band shift of 0. `cfg_error` is 0 and `fb_quarters` is 4. Every pixel goes to chip 0 only, with sample range 0..0.
- R2: The configuration pins are sampled only on a clock edge where `frame_start` is 1. The new setup governs routing from the next cycle on. Pin changes while `frame_start` is 0 leave routing, `fb_quarters` and `cfg_error` unchanged.
- R3: Encodings: `cfg_chip_code` 0/1/2 means 1/2/4 chips, and `cfg_aa_code` 0/1/2 means 1/2/4 samples. With 1 or 2 samples, the band index is `pix_y >> cfg_band_shift` and the single owning chip is the band index modulo the chip count.
- R4: In 1-sample mode the owning chip gets sample range first=0, last=0. In 2-sample mode it gets first=0, last=1. Chips that are not selected report first=0, last=0.
- R5: In 4-sample mode, the owning pair is p = band index modulo (chip count / 2). Chip 2p gets samples 0..1 and chip 2p+1 gets samples 2..3, for the same pixel. With 2 chips, both chips take every pixel.
- R6: `pix_ready` is 1 exactly when every chip selected for the current pixel has `chip_ready` set. `chip_valid` is the selected set when `pix_valid` and `pix_ready` are both 1, and 0 otherwise.
- R7: `fb_quarters` equals 4 × (samples produced per chip) / (number of chip groups that share the screen by banding). The values are: 1 chip/1 sample 4; 1/2 8; 2/1 2; 2/2 4; 2/4 8; 4/1 1; 4/2 2; 4/4 4.
- R8: A code of 3 in either field, or 4 samples with 1 chip, sets `cfg_error` to 1. The block then acts as one chip at one sample per pixel (chip 0 only, range 0..0, `fb_quarters` 4) until a valid setup is captured.
- R9: `chip_x` and `chip_y` carry `pix_x` and `pix_y` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Capture strobe for the configuration pins |
| cfg_chip_code | input | 2 | Chip count code (0:1, 1:2, 2:4) |
| cfg_aa_code | input | 2 | Samples per pixel code (0:1, 1:2, 2:4) |
| cfg_band_shift | input | 4 | log2 of band height in scanlines |
| pix_valid | input | 1 | Upstream pixel present |
| pix_x | input | 12 | Pixel column |
| pix_y | input | 12 | Pixel row |
| pix_ready | output | 1 | All selected chips can accept |
| chip_ready | input | 4 | Per-chip accept |
| chip_valid | output | 4 | Per-chip pixel transfer |
| chip_x | output | 12 | Column sent to chips |
| chip_y | output | 12 | Row sent to chips |
| chip_smp_first | output | 4x2 | First sample index per chip |
| chip_smp_last | output | 4x2 | Last sample index per chip |
| fb_quarters | output | 4 | Per-chip storage in quarter frames |
| cfg_error | output | 1 | Unsupported setup captured |

## Verification
Routing, ranges, `pix_ready` and the forwarded coordinates are combinational, so they are due in the same cycle as the pixel. The bench drives each pixel on a falling edge and compares one time unit later, before the next rising edge. The configuration outputs and any routing change are due one rising edge after a `frame_start` cycle. The bench therefore drops `frame_start` on the next falling edge and only then compares. For the ignored mid-frame changes, it lets several rising edges pass before comparing.

// File: rtl/band_pkg.sv
package band_pkg;
    localparam int CHIP_SLOTS   = 4;
    localparam int CHIP_IDX_W   = $clog2(CHIP_SLOTS);
    localparam int SMP_IDX_W    = 2;
    localparam int BAND_SHIFT_W = 4;
    localparam int FBQ_W        = 4;

    typedef struct packed {
        logic [1:0]              chips_log2;
        logic [1:0]              aa_log2;
        logic [BAND_SHIFT_W-1:0] band_shift;
        logic                    err;
    } act_cfg_t;

    localparam act_cfg_t CFG_RESET = '{chips_log2: 2'd0, aa_log2: 2'd0,
                                       band_shift: '0, err: 1'b0};

    typedef struct packed {
        logic [SMP_IDX_W-1:0] first;
        logic [SMP_IDX_W-1:0] last;
    } smp_range_t;

    // Reject codes the hardware cannot honour; fall back to one chip, one sample.
    function automatic act_cfg_t sanitize(input logic [1:0] cc, input logic [1:0] ac,
                                          input logic [BAND_SHIFT_W-1:0] sh);
        act_cfg_t r;
        logic bad;
        bad = (cc == 2'd3) || (ac == 2'd3) || ((ac == 2'd2) && (cc == 2'd0));
        r.chips_log2 = bad ? 2'd0 : cc;
        r.aa_log2    = bad ? 2'd0 : ac;
        r.band_shift = sh;
        r.err        = bad;
        return r;
    endfunction

    // Banding groups: pairs of chips in 4-sample mode, single chips otherwise.
    function automatic logic [1:0] groups_log2(input logic [1:0] chips, input logic [1:0] aa);
        return (aa == 2'd2) ? chips - 2'd1 : chips;
    endfunction

    // Storage per chip in quarter frames: samples per chip over banding share.
    function automatic logic [FBQ_W-1:0] fb_quarters_of(input logic [1:0] chips,
                                                        input logic [1:0] aa);
        logic [FBQ_W-1:0] base;
        base = (aa != 2'd0) ? FBQ_W'(8) : FBQ_W'(4);
        return base >> groups_log2(chips, aa);
    endfunction
endpackage

// File: rtl/band_cfg_hold.sv
module band_cfg_hold
    import band_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_start,
    input  logic [1:0]              chip_code,
    input  logic [1:0]              aa_code,
    input  logic [BAND_SHIFT_W-1:0] band_shift,
    output act_cfg_t                cfg,
    output logic [FBQ_W-1:0]        fbq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (frame_start) begin
            cfg <= sanitize(chip_code, aa_code, band_shift);
        end
    end

    assign fbq = fb_quarters_of(cfg.chips_log2, cfg.aa_log2);
endmodule

// File: rtl/band_owner_sel.sv
module band_owner_sel
    import band_pkg::*;
#(
    parameter int YW = 12
) (
    input  logic [1:0]              chips_log2,
    input  logic [1:0]              aa_log2,
    input  logic [BAND_SHIFT_W-1:0] band_shift,
    input  logic [YW-1:0]           y,
    output logic [CHIP_SLOTS-1:0]   sel,
    output smp_range_t [CHIP_SLOTS-1:0] rng
);
    logic                  pair_mode;
    logic [1:0]            glog2;
    logic [CHIP_IDX_W-1:0] gmask;
    logic [CHIP_IDX_W-1:0] group;
    logic [YW-1:0]         band_idx;

    assign pair_mode = (aa_log2 == 2'd2);
    assign glog2     = groups_log2(chips_log2, aa_log2);
    assign gmask     = CHIP_IDX_W'((1 << glog2) - 1);
    assign band_idx  = y >> band_shift;
    assign group     = band_idx[CHIP_IDX_W-1:0] & gmask;

    for (genvar i = 0; i < CHIP_SLOTS; i++) begin : g_chip
        localparam logic [CHIP_IDX_W-1:0] IDX = CHIP_IDX_W'(i);
        localparam logic [CHIP_IDX_W-1:0] PAIR = IDX >> 1;
        logic hit;
        assign hit = pair_mode ? (PAIR == group) : (IDX == group);
        assign sel[i] = hit;
        assign rng[i].first = (hit && pair_mode && IDX[0]) ? 2'd2 : 2'd0;
        assign rng[i].last  = !hit ? 2'd0 :
                              pair_mode ? (IDX[0] ? 2'd3 : 2'd1) :
                              (aa_log2 == 2'd1) ? 2'd1 : 2'd0;
    end
endmodule

// File: rtl/band_handshake.sv
module band_handshake
    import band_pkg::*;
(
    input  logic                  pix_valid,
    input  logic [CHIP_SLOTS-1:0] sel,
    input  logic [CHIP_SLOTS-1:0] chip_ready,
    output logic                  pix_ready,
    output logic [CHIP_SLOTS-1:0] chip_valid
);
    // Every selected chip must accept, so a pixel lands on all of them or none.
    assign pix_ready  = &(chip_ready | ~sel);
    assign chip_valid = (pix_valid && pix_ready) ? sel : '0;
endmodule

// File: rtl/band_dispatch.sv
module band_dispatch
    import band_pkg::*;
#(
    parameter int XW = 12,
    parameter int YW = 12
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            frame_start,
    input  logic [1:0]                      cfg_chip_code,
    input  logic [1:0]                      cfg_aa_code,
    input  logic [BAND_SHIFT_W-1:0]         cfg_band_shift,
    input  logic                            pix_valid,
    input  logic [XW-1:0]                   pix_x,
    input  logic [YW-1:0]                   pix_y,
    output logic                            pix_ready,
    input  logic [CHIP_SLOTS-1:0]           chip_ready,
    output logic [CHIP_SLOTS-1:0]           chip_valid,
    output logic [XW-1:0]                   chip_x,
    output logic [YW-1:0]                   chip_y,
    output logic [CHIP_SLOTS-1:0][SMP_IDX_W-1:0] chip_smp_first,
    output logic [CHIP_SLOTS-1:0][SMP_IDX_W-1:0] chip_smp_last,
    output logic [FBQ_W-1:0]                fb_quarters,
    output logic                            cfg_error
);
    act_cfg_t                    cfg;
    logic [CHIP_SLOTS-1:0]       sel;
    smp_range_t [CHIP_SLOTS-1:0] rng;

    band_cfg_hold u_cfg (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .chip_code  (cfg_chip_code),
        .aa_code    (cfg_aa_code),
        .band_shift (cfg_band_shift),
        .cfg        (cfg),
        .fbq        (fb_quarters)
    );

    band_owner_sel #(.YW(YW)) u_sel (
        .chips_log2(cfg.chips_log2),
        .aa_log2   (cfg.aa_log2),
        .band_shift(cfg.band_shift),
        .y         (pix_y),
        .sel       (sel),
        .rng       (rng)
    );

    band_handshake u_hs (
        .pix_valid (pix_valid),
        .sel       (sel),
        .chip_ready(chip_ready),
        .pix_ready (pix_ready),
        .chip_valid(chip_valid)
    );

    for (genvar i = 0; i < CHIP_SLOTS; i++) begin : g_out
        assign chip_smp_first[i] = rng[i].first;
        assign chip_smp_last[i]  = rng[i].last;
    end

    assign chip_x    = pix_x;
    assign chip_y    = pix_y;
    assign cfg_error = cfg.err;
endmodule

// File: rtl/band_dispatch_chk.sv
module band_dispatch_chk
    import band_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic                            frame_start,
    input logic                            pix_valid,
    input logic                            pix_ready,
    input logic [CHIP_SLOTS-1:0]           chip_ready,
    input logic [CHIP_SLOTS-1:0]           chip_valid,
    input logic [CHIP_SLOTS-1:0][SMP_IDX_W-1:0] chip_smp_first,
    input logic [CHIP_SLOTS-1:0][SMP_IDX_W-1:0] chip_smp_last,
    input logic [FBQ_W-1:0]                fb_quarters,
    input logic                            cfg_error
);
    // R6: a transfer only reaches chips that accept it
    a_r6_valid_to_ready: assert property (@(posedge clk) disable iff (rst)
        (chip_valid & ~chip_ready) == '0);

    // R6: a stalled pixel reaches no chip
    a_r6_stall_quiet: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !pix_ready) |-> chip_valid == '0);

    // R3 / R5: at most a pair of chips takes any pixel
    a_r5_at_most_pair: assert property (@(posedge clk) disable iff (rst)
        $countones(chip_valid) <= 2);

    // R2: setup outputs move only after a capture strobe
    a_r2_hold_midframe: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_start) |-> ($stable(fb_quarters) && $stable(cfg_error)));

    // R8: error fallback is one sample, single-frame storage
    a_r8_fallback: assert property (@(posedge clk) disable iff (rst)
        cfg_error |-> (fb_quarters == FBQ_W'(4) && chip_smp_last == '0));

    // R4 / R5: every range is ordered
    for (genvar i = 0; i < CHIP_SLOTS; i++) begin : g_rng
        a_r4_range_order: assert property (@(posedge clk) disable iff (rst)
            chip_smp_first[i] <= chip_smp_last[i]);
    end
endmodule

bind band_dispatch band_dispatch_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_start   (frame_start),
    .pix_valid     (pix_valid),
    .pix_ready     (pix_ready),
    .chip_ready    (chip_ready),
    .chip_valid    (chip_valid),
    .chip_smp_first(chip_smp_first),
    .chip_smp_last (chip_smp_last),
    .fb_quarters   (fb_quarters),
    .cfg_error     (cfg_error)
);

// File: tb/band_dispatch_tb.sv
module band_dispatch_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic [1:0]  cfg_chip_code = 2'd0;
    logic [1:0]  cfg_aa_code = 2'd0;
    logic [3:0]  cfg_band_shift = 4'd0;
    logic        pix_valid = 1'b0;
    logic [11:0] pix_x = '0;
    logic [11:0] pix_y = '0;
    logic        pix_ready;
    logic [3:0]  chip_ready = 4'hF;
    logic [3:0]  chip_valid;
    logic [11:0] chip_x;
    logic [11:0] chip_y;
    logic [3:0][1:0] chip_smp_first;
    logic [3:0][1:0] chip_smp_last;
    logic [3:0]  fb_quarters;
    logic        cfg_error;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // bench copy of the captured setup
    int m_cc = 0, m_ac = 0, m_sh = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    band_dispatch u_dut (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .cfg_chip_code(cfg_chip_code), .cfg_aa_code(cfg_aa_code),
        .cfg_band_shift(cfg_band_shift),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_ready(pix_ready),
        .chip_ready(chip_ready), .chip_valid(chip_valid),
        .chip_x(chip_x), .chip_y(chip_y),
        .chip_smp_first(chip_smp_first), .chip_smp_last(chip_smp_last),
        .fb_quarters(fb_quarters), .cfg_error(cfg_error)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected outputs from the requirement text.
    task automatic expect_route(input int y, output int mask, output int first[4],
                                output int last[4], output int fbq, output int err);
        int cc, ac, n, band, p, o;
        cc = m_cc; ac = m_ac;
        err = (cc == 3 || ac == 3 || (ac == 2 && cc == 0)) ? 1 : 0;
        if (err != 0) begin cc = 0; ac = 0; end
        n = 1 << cc;
        band = y >> m_sh;
        mask = 0;
        for (int i = 0; i < 4; i++) begin first[i] = 0; last[i] = 0; end
        if (ac == 2) begin
            p = band % (n / 2);
            mask = 3 << (2 * p);
            first[2*p] = 0; last[2*p] = 1;
            first[2*p+1] = 2; last[2*p+1] = 3;
            fbq = 8 / (n / 2);
        end else begin
            o = band % n;
            mask = 1 << o;
            last[o] = (ac == 1) ? 1 : 0;
            fbq = ((ac == 1) ? 8 : 4) / n;
        end
    endtask

    task automatic send_pix(input string tag, input int x, input int y, input int rdy);
        int mask, fbq, err, exp_rdy;
        int first[4];
        int last[4];
        @(negedge clk);
        pix_valid = 1'b1; pix_x = 12'(x); pix_y = 12'(y); chip_ready = 4'(rdy);
        #1;
        expect_route(y, mask, first, last, fbq, err);
        exp_rdy = ((mask & ~rdy) == 0) ? 1 : 0;
        cmp({tag, " pix_ready"}, int'(pix_ready), exp_rdy);
        cmp({tag, " chip_valid"}, int'(chip_valid), exp_rdy != 0 ? mask : 0);
        for (int i = 0; i < 4; i++) begin
            cmp($sformatf("%s first[%0d]", tag, i), int'(chip_smp_first[i]), first[i]);
            cmp($sformatf("%s last[%0d]", tag, i), int'(chip_smp_last[i]), last[i]);
        end
        cmp({tag, " R7 fb_quarters"}, int'(fb_quarters), fbq);
        cmp({tag, " R8 cfg_error"}, int'(cfg_error), err);
    endtask

    task automatic capture(input int cc, input int ac, input int sh);
        @(negedge clk);
        cfg_chip_code = 2'(cc); cfg_aa_code = 2'(ac); cfg_band_shift = 4'(sh);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        m_cc = cc; m_ac = ac; m_sh = sh;
    endtask

    task automatic t_reset;
        send_pix("R1 reset y=0", 3, 0, 15);
        send_pix("R1 reset y=77", 5, 77, 15);
        cmp("R1 fb_quarters", int'(fb_quarters), 4);
        cmp("R1 cfg_error", int'(cfg_error), 0);
    endtask

    task automatic t_band2;
        capture(1, 0, 2);
        for (int y = 0; y < 16; y += 3) send_pix("R3 2chip 1smp", y, y, 15);
    endtask

    task automatic t_band4;
        capture(2, 0, 3);
        for (int y = 0; y < 64; y += 5) send_pix("R3 4chip 1smp", 1, y, 15);
        capture(2, 1, 0);
        for (int y = 0; y < 6; y++) send_pix("R4 4chip 2smp", 2, y, 15);
    endtask

    task automatic t_aa2;
        capture(1, 1, 1);
        for (int y = 0; y < 8; y++) send_pix("R4 2chip 2smp", 9, y, 15);
        capture(0, 1, 0);
        send_pix("R7 1chip 2smp", 0, 4, 15);
    endtask

    task automatic t_aa4;
        capture(1, 2, 2);
        send_pix("R5 2chip 4smp", 7, 0, 15);
        send_pix("R5 2chip 4smp band1", 7, 4, 15);
        send_pix("R6 chip1 busy", 7, 4, 4'b1101);
        send_pix("R6 chip0 busy", 7, 9, 4'b1110);
        capture(2, 2, 1);
        for (int y = 0; y < 8; y++) send_pix("R5 4chip 4smp", 3, y, 15);
        send_pix("R6 other pair busy", 3, 0, 4'b1100);
        send_pix("R6 own pair busy", 3, 2, 4'b1011);
    endtask

    task automatic t_ready_band;
        capture(2, 0, 0);
        send_pix("R6 owner busy", 1, 2, 4'b1011);
        send_pix("R6 non-owner busy", 1, 2, 4'b0100);
        @(negedge clk);
        pix_valid = 1'b0; pix_y = 12'd1; chip_ready = 4'hF;
        #1;
        cmp("R6 idle chip_valid", int'(chip_valid), 0);
    endtask

    task automatic t_midframe;
        capture(1, 0, 0);
        @(negedge clk);
        cfg_chip_code = 2'd2; cfg_aa_code = 2'd2; cfg_band_shift = 4'd5;
        repeat (3) @(posedge clk);
        for (int y = 0; y < 4; y++) send_pix("R2 ignored change", 0, y, 15);
        cmp("R2 fb held", int'(fb_quarters), 2);
        capture(2, 2, 5);
        send_pix("R2 after strobe", 0, 40, 15);
    endtask

    task automatic t_error;
        capture(0, 2, 0);
        send_pix("R8 1chip 4smp", 0, 1, 15);
        send_pix("R8 1chip 4smp y=9", 0, 9, 15);
        capture(3, 0, 0);
        send_pix("R8 chip code 3", 0, 3, 15);
        capture(1, 3, 0);
        send_pix("R8 aa code 3", 0, 1, 15);
        capture(1, 1, 0);
        send_pix("R8 recovery", 0, 1, 15);
    endtask

    task automatic t_fb_table;
        int exp_tab[3][3] = '{'{4, 8, -1}, '{2, 4, 8}, '{1, 2, 4}};
        for (int c = 0; c < 3; c++)
            for (int a = 0; a < 3; a++) begin
                capture(c, a, 0);
                cmp($sformatf("R7 fb c%0d a%0d", c, a), int'(fb_quarters),
                    exp_tab[c][a] < 0 ? 4 : exp_tab[c][a]);
            end
    endtask

    task automatic t_coord;
        @(negedge clk);
        pix_valid = 1'b1; pix_x = 12'd4095; pix_y = 12'd2049;
        #1;
        cmp("R9 chip_x", int'(chip_x), 4095);
        cmp("R9 chip_y", int'(chip_y), 2049);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_band2();
        t_band4();
        t_aa2();
        t_aa4();
        t_ready_band();
        t_midframe();
        t_error();
        t_fb_table();
        t_coord();
        @(negedge clk);
        pix_valid = 1'b0;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule